// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block is the processor-facing side of one PS/2 keyboard or mouse port. Software sees a small map of word-spaced registers on a simple synchronous bus with address, read strobe, write strobe and 32-bit data. The block has one interrupt line. Toward the port hardware, it takes received bytes from a receive queue through a valid/pop handshake, and it hands bytes to a transmitter as a one-cycle strobe with a byte.

Reading the data register consumes a queued byte only if one is waiting. That byte is kept as the last received byte. A read with nothing queued returns the kept byte again. The status register reports the parity of the kept byte and whether a byte is waiting. The interrupt is the OR of two terms: a waiting byte gated by one control bit, and a second control bit that forces the line high. A read-only window at the top of the 4 KiB map returns eight identification bytes.

Read data is combinational in the cycle of the read strobe. Register updates and the byte pop take effect on that same clock edge.

Top module: `ps2_port_regs`

## Requirements
- R1: A synchronous active-high reset sets the control register, the divisor register and the last received byte to zero. After reset the interrupt output is low.
- R2: Offset 0x00 is the control register. A write stores the low 8 bits of the write data. A read returns them with bits 31:8 as zero.
- R3: The interrupt output equals (byte waiting AND control bit 4) OR control bit 3, where byte waiting is rx_valid. It follows rx_valid in the same cycle and follows the control register from the edge that writes it.
- R4: A read of offset 0x04 returns 1 in bit 6, rx_valid in bit 4, and the parity of the last received byte in bit 2. The parity bit is 1 when that byte has an odd number of set bits. All other bits read 0.
- R5: A read of offset 0x08 while rx_valid is 1 returns rx_byte in bits 7:0 in the same cycle and asserts rx_pop for that cycle. From the next edge on, that byte is the last received byte.
- R6: A read of offset 0x08 while rx_valid is 0 returns the last received byte, leaves rx_pop low, and does not change the last received byte.
- R7: A read of offset 0x10 returns rx_valid in bit 0 and 1 in bit 1. All other bits read 0.
- R8: Reads at offsets 0xFE0 + 4*i, for i from 0 to 7, return 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R9: A write to offset 0x08 asserts tx_strobe in that cycle and drives tx_byte with bits 7:0 of the write data.
- R10: Offset 0x0C is the divisor register. A write stores the low 8 bits of the write data. A read returns them with bits 31:8 as zero.
- R11: Reads of any other offset return 0. Writes to offsets 0x04, 0x10, the identification window or any unmapped offset change no register and strobe nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset; bits 1:0 are ignored |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Receive queue holds a byte |
| rx_byte | input | 8 | Head byte of the receive queue |
| rx_pop | output | 1 | Consume the head byte this cycle |
| tx_strobe | output | 1 | Send tx_byte this cycle |
| tx_byte | output | 8 | Byte to transmit |

## Verification
A wrong last received byte shows up in two places. A non-pending data read returns it directly. The status parity bit also changes, in the very next cycle after the faulty pop or missed pop. A wrong control value shows in the next cycle through the interrupt line and the control readback. A pop that fires without a waiting byte, or one that fails to fire, is visible on rx_pop in the same cycle as the read strobe. It also changes the value that the following data read returns.

// File: rtl/ps2r_pkg.sv
package ps2r_pkg;
  localparam int WI_CTRL   = 0;
  localparam int WI_STAT   = 1;
  localparam int WI_DATA   = 2;
  localparam int WI_DIV    = 3;
  localparam int WI_IRQST  = 4;
  localparam int ID_OFFSET = 12'hFE0;
  localparam int IRQ_EN_BIT    = 4;
  localparam int IRQ_FORCE_BIT = 3;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h50;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/ps2r_cfg_reg.sv
module ps2r_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end

  // R2 / R10: a write lands in the register
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(d)));
  // R11: without a write the register holds
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/ps2r_rx_latch.sv
module ps2r_rx_latch #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_hit,
  input  logic          rx_valid,
  input  logic [BW-1:0] rx_byte,
  output logic          rx_pop,
  output logic [BW-1:0] rd_byte,
  output logic [BW-1:0] last_q,
  output logic          parity
);
  assign rx_pop  = rd_hit && rx_valid;
  assign rd_byte = rx_pop ? rx_byte : last_q;
  assign parity  = ^last_q;

  always_ff @(posedge clk) begin
    if (rst)         last_q <= '0;
    else if (rx_pop) last_q <= rx_byte;
  end

  // R5: a pop needs a waiting byte, and the popped byte is kept
  a_r5_pop_needs_valid: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> rx_valid);
  a_r5_kept_byte: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> (last_q == $past(rx_byte)));
  // R6: no pop leaves the kept byte alone
  a_r6_no_pop_stable: assert property (@(posedge clk) disable iff (rst)
    !rx_pop |=> $stable(last_q));
endmodule

// File: rtl/ps2r_id_table.sv
module ps2r_id_table #(
  parameter int IW = 3
) (
  input  logic [IW-1:0] idx,
  output logic [7:0]    id_val
);
  import ps2r_pkg::*;
  always_comb id_val = id_byte(3'(idx));
endmodule

// File: rtl/ps2_port_regs.sv
module ps2_port_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_pop,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte
);
  import ps2r_pkg::*;

  localparam int WIDX_W  = ADDR_W - 2;
  localparam int ID_WBASE = ID_OFFSET >> 2;

  logic [WIDX_W-1:0] widx;
  logic hit_ctrl, hit_stat, hit_data, hit_div, hit_irqst, hit_id;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [BYTE_W-1:0] rd_byte, last_q;
  logic              parity;
  logic [7:0]        id_val;

  assign widx      = bus_addr[ADDR_W-1:2];
  assign hit_ctrl  = (widx == WIDX_W'(WI_CTRL));
  assign hit_stat  = (widx == WIDX_W'(WI_STAT));
  assign hit_data  = (widx == WIDX_W'(WI_DATA));
  assign hit_div   = (widx == WIDX_W'(WI_DIV));
  assign hit_irqst = (widx == WIDX_W'(WI_IRQST));
  assign hit_id    = (widx >= WIDX_W'(ID_WBASE));

  ps2r_cfg_reg #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst(rst), .we(bus_wr && hit_ctrl),
    .d(bus_wdata[CTRL_W-1:0]), .q(ctrl_q));

  ps2r_cfg_reg #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .we(bus_wr && hit_div),
    .d(bus_wdata[DIV_W-1:0]), .q(div_q));

  ps2r_rx_latch #(.BW(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .rd_hit(bus_rd && hit_data),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_pop(rx_pop),
    .rd_byte(rd_byte), .last_q(last_q), .parity(parity));

  ps2r_id_table #(.IW(3)) u_id (.idx(bus_addr[4:2]), .id_val(id_val));

  assign tx_strobe = bus_wr && hit_data;
  assign tx_byte   = bus_wdata[BYTE_W-1:0];
  assign irq       = (rx_valid && ctrl_q[IRQ_EN_BIT]) || ctrl_q[IRQ_FORCE_BIT];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_ctrl)       bus_rdata = DATA_W'(ctrl_q);
      else if (hit_stat)  bus_rdata = DATA_W'({1'b1, 1'b0, rx_valid, 1'b0, parity, 2'b00});
      else if (hit_data)  bus_rdata = DATA_W'(rd_byte);
      else if (hit_div)   bus_rdata = DATA_W'(div_q);
      else if (hit_irqst) bus_rdata = DATA_W'({1'b1, rx_valid});
      else if (hit_id)    bus_rdata = DATA_W'(id_val);
    end
  end

  // R3: the force bit always raises the line
  a_r3_force_high: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[IRQ_FORCE_BIT] |-> irq);
  // R3: with both control bits clear the line stays low
  a_r3_quiet_low: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[IRQ_FORCE_BIT] && !ctrl_q[IRQ_EN_BIT]) |-> !irq);
  // R9: a transmit strobe only comes from a bus write
  a_r9_tx_from_write: assert property (@(posedge clk) disable iff (rst)
    tx_strobe |-> bus_wr);
  // R5: a pop only comes from a bus read
  a_r5_pop_from_read: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> bus_rd);
endmodule

// File: tb/sim_ps2_port_regs.sv
`timescale 1ns/1ps
module sim_ps2_port_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rx_valid = 1'b0, rx_pop, tx_strobe;
  logic [7:0]  rx_byte = '0, tx_byte;

  int checks = 0, errors = 0;
  int m_ctrl = 0, m_div = 0, m_last = 0;
  int id_tab[8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always #10 clk = ~clk;

  ps2_port_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_pop(rx_pop), .tx_strobe(tx_strobe), .tx_byte(tx_byte));

  function automatic int odd_ones(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) if ((v >> i) & 1) n++;
    return n % 2;
  endfunction

  function automatic int exp_read(int a, int v, int b);
    int w = a >> 2;
    if (w == 0) return m_ctrl;
    if (w == 1) return 64 + (v ? 16 : 0) + (odd_ones(m_last) ? 4 : 0);
    if (w == 2) return v ? b : m_last;
    if (w == 3) return m_div;
    if (w == 4) return 2 + v;
    if (a >= 12'hFE0) return id_tab[(a - 12'hFE0) >> 2];
    return 0;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, int a, bit rd, bit wr, int wd, bit v, int b);
    int e_rd;
    bit e_pop, e_tx, e_irq;
    @(negedge clk);
    bus_addr = 12'(a); bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    rx_valid = v; rx_byte = 8'(b);
    #1;
    e_rd  = rd ? exp_read(a & 12'hFFC, v, b) : 0;
    e_pop = rd && ((a >> 2) == 2) && v;
    e_tx  = wr && ((a >> 2) == 2);
    e_irq = (v && m_ctrl[4]) || m_ctrl[3];
    if (rd) cmp(tag, "rdata", bus_rdata, e_rd);
    cmp(tag, "irq", int'(irq), int'(e_irq));
    cmp(tag, "rx_pop", int'(rx_pop), int'(e_pop));
    cmp(tag, "tx_strobe", int'(tx_strobe), int'(e_tx));
    if (e_tx) cmp(tag, "tx_byte", int'(tx_byte), wd & 255);
    @(posedge clk);
    if (wr && (a >> 2) == 0) m_ctrl = wd & 255;
    if (wr && (a >> 2) == 3) m_div = wd & 255;
    if (e_pop) m_last = b & 255;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    step("R1", 12'h000, 1, 0, 0, 0, 0);
    step("R1", 12'h00C, 1, 0, 0, 0, 0);
    step("R1", 12'h008, 1, 0, 0, 0, 0);
    step("R1", 12'h004, 1, 0, 0, 1, 8'h11);
    // R2 control store and readback
    step("R2", 12'h000, 0, 1, 32'hFFFF_FF18, 0, 0);
    step("R2", 12'h000, 1, 0, 0, 0, 0);
    // R3 interrupt combinations
    step("R3", 12'h000, 0, 1, 32'h10, 0, 0);
    step("R3", 12'h100, 0, 0, 0, 0, 0);
    step("R3", 12'h100, 0, 0, 0, 1, 8'h42);
    step("R3", 12'h000, 0, 1, 32'h08, 1, 8'h42);
    step("R3", 12'h100, 0, 0, 0, 0, 0);
    step("R3", 12'h000, 0, 1, 32'h00, 1, 8'h42);
    step("R3", 12'h100, 0, 0, 0, 1, 8'h42);
    // R5 pending read pops, R4 parity of odd byte
    step("R5", 12'h008, 1, 0, 0, 1, 8'hA7);
    step("R4", 12'h004, 1, 0, 0, 0, 0);
    step("R4", 12'h004, 1, 0, 0, 1, 8'h01);
    // R6 non-pending read repeats
    step("R6", 12'h008, 1, 0, 0, 0, 8'h5A);
    step("R6", 12'h008, 1, 0, 0, 0, 0);
    // R5 even parity byte
    step("R5", 12'h008, 1, 0, 0, 1, 8'h33);
    step("R4", 12'h004, 1, 0, 0, 0, 0);
    step("R5", 12'h008, 1, 0, 0, 1, 8'h80);
    step("R4", 12'h006, 1, 0, 0, 0, 0);
    // R7 interrupt status
    step("R7", 12'h010, 1, 0, 0, 0, 0);
    step("R7", 12'h010, 1, 0, 0, 1, 8'h77);
    // R8 identification window
    for (int i = 0; i < 8; i++) step("R8", 12'hFE0 + 4 * i, 1, 0, 0, 0, 0);
    // R9 transmit
    step("R9", 12'h008, 0, 1, 32'h1C5, 0, 0);
    step("R9", 12'h008, 0, 1, 32'h03, 1, 8'h99);
    step("R9", 12'h008, 1, 0, 0, 0, 0);
    // R10 divisor
    step("R10", 12'h00C, 0, 1, 32'hABCD, 0, 0);
    step("R10", 12'h00C, 1, 0, 0, 0, 0);
    // R11 unmapped reads and ignored writes
    step("R11", 12'h014, 1, 0, 0, 1, 8'h12);
    step("R11", 12'h800, 1, 0, 0, 0, 0);
    step("R11", 12'h004, 0, 1, 32'hFF, 0, 0);
    step("R11", 12'h010, 0, 1, 32'hFF, 0, 0);
    step("R11", 12'hFE0, 0, 1, 32'hFF, 0, 0);
    step("R11", 12'h020, 0, 1, 32'hFF, 0, 0);
    step("R11", 12'h000, 1, 0, 0, 0, 0);
    step("R11", 12'h00C, 1, 0, 0, 0, 0);
    step("R11", 12'h008, 1, 0, 0, 0, 0);
    // R1 reset again clears state
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    m_ctrl = 0; m_div = 0; m_last = 0;
    step("R1", 12'h000, 1, 0, 0, 1, 8'h3C);
    step("R1", 12'h00C, 1, 0, 0, 0, 0);
    step("R1", 12'h008, 1, 0, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule